// File: doc/BRIEF.md
# Transmit PLL Power-Up Reset Sequencer

This block brings a bonded group of transmit-only serial channels out of reset in a safe order. They all share one transmit PLL. After a reset request, it keeps the PLL in power-down for a minimum time. The hold time comes from the clock frequency and a minimum duration in nanoseconds. It then releases the PLL and waits for the PLL to report lock. The datapath reset is released only once that lock report has passed through a two-stage synchronizer. Every channel in the group comes out of reset on the same cycle.

Once the link is running, a drop in lock puts the datapath back into reset. The sequencer then waits for lock again without powering the PLL down. An optional watchdog limits the wait for lock. When it runs out, the PLL is power-cycled and the sequence starts over. A ready flag tells downstream logic when the channels may carry traffic.

Top module: `txpll_rst_seq`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `pll_pd` is 1, every bit of `tx_rst` is 1 and `ready` is 0.
- R2: After `rst` falls, `pll_pd` stays 1 for exactly PD_CYC = ceil(CLK_MHZ*PD_NS/1000) clock cycles. This is 250 at the defaults of 250 MHz and 1000 ns.
- R3: While `pll_pd` is 1, every bit of `tx_rst` is 1.
- R4: `lock_in` is asynchronous and passes through two flops. `tx_rst` therefore falls on the second rising clock edge after `lock_in` rises, and not on the first.
- R5: `ready` rises exactly one cycle after `tx_rst` falls. `ready` is 1 only when `pll_pd` is 0 and all of `tx_rst` is 0.
- R6: When `lock_in` falls while ready, `tx_rst` rises and `ready` falls on the second edge after the fall, and `pll_pd` stays 0. When lock returns, the release follows R4 and R5.
- R7: If the synchronized lock stays low for LOCK_TMO consecutive waiting cycles (400 by default), `pll_pd` returns to 1 and a full PD_CYC power-down follows.
- R8: If the synchronized lock becomes 1 in the last waiting cycle before the timeout, the lock wins. `pll_pd` stays 0 and `tx_rst` is released.
- R9: A high `lock_in` during power-down neither shortens the power-down nor releases `tx_rst`.
- R10: All NUM_CH bits of `tx_rst` are always equal (NUM_CH is 4 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset request; restarts the sequence |
| lock_in | input | 1 | PLL lock indication, asynchronous to clk |
| pll_pd | output | 1 | PLL power-down, active high |
| tx_rst | output | NUM_CH | Transmit datapath reset, one bit per channel, active high |
| ready | output | 1 | Channels released and carrying traffic |

## Verification
Two events can land in the same cycle: the lock watchdog expiring and the synchronized lock arriving. The bench counts cycles from the moment power-down ends. It raises `lock_in` so that the synchronized lock first reads 1 in the final waiting cycle, and expects the channels to be released with no new power-down. It then repeats the test with `lock_in` one cycle later. In that case a second power-down must begin. The bench also holds lock high through power-down and drops lock while the link is running, to confirm the release ordering around the synchronizer delay.

// File: rtl/txpll_rst_pkg.sv
package txpll_rst_pkg;

    typedef enum logic [1:0] {
        SEQ_PWRDN = 2'd0,
        SEQ_WAIT  = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic pd;
        logic hold;
        logic rdy;
    } seq_out_t;

    // Cycles covering a minimum time: ceil(mhz * ns / 1000)
    function automatic int unsigned min_cycles(input int unsigned mhz, input int unsigned ns);
        return (mhz * ns + 999) / 1000;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit > 2) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/txpll_sync2.sv
module txpll_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic stage1;
    logic stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= 1'b0;
            stage2 <= 1'b0;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;
endmodule

// File: rtl/txpll_cycle_timer.sv
module txpll_cycle_timer
    import txpll_rst_pkg::*;
#(
    parameter int unsigned LIMIT = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic done
);
    localparam int unsigned W = cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LAST);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST); // R2
endmodule

// File: rtl/txpll_seq_fsm.sv
module txpll_seq_fsm
    import txpll_rst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lock_s,
    input  logic       pd_done,
    input  logic       tmo_done,
    output seq_state_e state,
    output seq_out_t   outs
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_PWRDN: if (pd_done) nxt = SEQ_WAIT;
            SEQ_WAIT: begin
                if (lock_s)        nxt = SEQ_RUN;
                else if (tmo_done) nxt = SEQ_PWRDN;
            end
            SEQ_RUN:   if (!lock_s) nxt = SEQ_WAIT;
            default:   nxt = SEQ_PWRDN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SEQ_PWRDN;
        else     state <= nxt;
    end

    always_comb begin
        outs.pd   = (state == SEQ_PWRDN);
        outs.hold = (state == SEQ_PWRDN) || !lock_s;
        outs.rdy  = (state == SEQ_RUN) && lock_s;
    end

    AST_PD_HOLDS_RST: assert property (@(posedge clk) disable iff (rst)
        outs.pd |-> outs.hold); // R3
    AST_RDY_CLEAN: assert property (@(posedge clk) disable iff (rst)
        outs.rdy |-> (!outs.pd && !outs.hold)); // R5
    AST_PD_FULL: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_WAIT && $past(state) == SEQ_PWRDN) |-> $past(pd_done)); // R2
    AST_LOCK_WINS: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_PWRDN && $past(state) == SEQ_WAIT) |-> ($past(!lock_s) && $past(tmo_done))); // R8
endmodule

// File: rtl/txpll_rst_seq.sv
module txpll_rst_seq
    import txpll_rst_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 250,
    parameter int unsigned PD_NS    = 1000,
    parameter int unsigned LOCK_TMO = 400,
    parameter bit          TMO_EN   = 1'b1,
    parameter int unsigned NUM_CH   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_in,
    output logic              pll_pd,
    output logic [NUM_CH-1:0] tx_rst,
    output logic              ready
);
    localparam int unsigned PD_CYC = min_cycles(CLK_MHZ, PD_NS);

    logic       lock_s;
    logic       pd_done;
    logic       tmo_done;
    seq_state_e state;
    seq_out_t   outs;

    txpll_sync2 u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (lock_in),
        .q_sync  (lock_s)
    );

    txpll_cycle_timer #(.LIMIT(PD_CYC)) u_pd_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (state != SEQ_PWRDN),
        .done  (pd_done)
    );

    generate
        if (TMO_EN) begin : g_tmo
            txpll_cycle_timer #(.LIMIT(LOCK_TMO)) u_tmo_timer (
                .clk   (clk),
                .rst   (rst),
                .clear (state != SEQ_WAIT),
                .done  (tmo_done)
            );
        end else begin : g_no_tmo
            assign tmo_done = 1'b0;
        end
    endgenerate

    txpll_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .lock_s   (lock_s),
        .pd_done  (pd_done),
        .tmo_done (tmo_done),
        .state    (state),
        .outs     (outs)
    );

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            assign tx_rst[ch] = outs.hold;
        end
    endgenerate

    assign pll_pd = outs.pd;
    assign ready  = outs.rdy;

    AST_RDY_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(tx_rst == '0)); // R5
    AST_RELEASE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        (tx_rst == '0) |-> lock_s); // R4
endmodule

// File: tb/tb_txpll_rst_seq.sv
`timescale 1ns/1ps
module tb_txpll_rst_seq;
    localparam int PD  = 250;
    localparam int TMO = 400;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           lock_in = 1'b0;
    logic           pll_pd;
    logic [NCH-1:0] tx_rst;
    logic           ready;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic  pd;
        logic  rs;
        logic  rdy;
        string req;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    txpll_rst_seq dut (
        .clk(clk), .rst(rst), .lock_in(lock_in),
        .pll_pd(pll_pd), .tx_rst(tx_rst), .ready(ready)
    );

    task automatic push(input logic pd, input logic rs, input logic rdy, input string req);
        exp_t e;
        e.pd = pd; e.rs = rs; e.rdy = rdy; e.req = req;
        sb.push_back(e);
    endtask

    task automatic chk_int(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: compares queued expectations against the ports after the negedge.
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0) begin
            exp_t e;
            logic [NCH-1:0] exp_rs;
            e = sb.pop_front();
            exp_rs = {NCH{e.rs}};
            n_chk++;
            if (pll_pd !== e.pd || tx_rst !== exp_rs || ready !== e.rdy) begin
                n_bad++;
                $display("FAIL %s: actual pd=%b rst=%b rdy=%b expected pd=%b rst=%b rdy=%b",
                         e.req, pll_pd, tx_rst, ready, e.pd, exp_rs, e.rdy);
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    // Counts samples with pll_pd at level lvl, from the current sample on; R3 checked each sample
    task automatic count_pd(input logic lvl, output int n);
        n = 0;
        while (pll_pd === lvl && n < 5000) begin
            if (lvl && tx_rst !== {NCH{1'b1}}) begin
                n_chk++; n_bad++;
                $display("FAIL R3: actual rst=%b expected all ones during power-down", tx_rst);
            end
            n++;
            step();
        end
    endtask

    initial begin
        int n;
        // R1: reset state
        repeat (3) step();
        push(1'b1, 1'b1, 1'b0, "R1");
        rst = 1'b0;
        lock_in = 1'b1;                 // R9: lock already high through power-down
        push(1'b1, 1'b1, 1'b0, "R1");
        count_pd(1'b1, n);
        chk_int(n, PD, "R2/R9");
        // pd just fell with lock synchronized: release now, ready next
        push(1'b0, 1'b0, 1'b0, "R5");
        step();
        push(1'b0, 1'b0, 1'b1, "R5");
        step();
        chk_int(int'(tx_rst == {NCH{tx_rst[0]}}), 1, "R10");

        // R6: loss of lock while running
        lock_in = 1'b0;
        step(); push(1'b0, 1'b0, 1'b1, "R6");
        step(); push(1'b0, 1'b1, 1'b0, "R6");
        step(); push(1'b0, 1'b1, 1'b0, "R6");
        lock_in = 1'b1;
        step(); push(1'b0, 1'b1, 1'b0, "R4");
        step(); push(1'b0, 1'b0, 1'b0, "R4");
        step(); push(1'b0, 1'b0, 1'b1, "R5");

        // R7: timeout then full power-down
        lock_in = 1'b0;
        step(); step(); push(1'b0, 1'b1, 1'b0, "R6");
        step();
        count_pd(1'b0, n);
        chk_int(n, TMO, "R7");
        count_pd(1'b1, n);
        chk_int(n, PD, "R7");
        // R8: synchronized lock lands on the last waiting cycle
        repeat (TMO - 3) step();
        lock_in = 1'b1;
        step(); push(1'b0, 1'b1, 1'b0, "R8");
        step(); push(1'b0, 1'b0, 1'b0, "R8");
        step(); push(1'b0, 1'b0, 1'b1, "R8");

        // R7: lock one cycle too late, so timeout wins
        lock_in = 1'b0;
        step(); step(); step();
        count_pd(1'b0, n);
        chk_int(n, TMO, "R7");
        count_pd(1'b1, n);
        chk_int(n, PD, "R7");
        repeat (TMO - 2) step();
        lock_in = 1'b1;
        step(); push(1'b0, 1'b1, 1'b0, "R7");
        step(); push(1'b1, 1'b1, 1'b0, "R7");
        count_pd(1'b1, n);
        chk_int(n, PD, "R2");
        push(1'b0, 1'b0, 1'b0, "R4");
        step(); push(1'b0, 1'b0, 1'b1, "R5");
        step(); step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #40000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule